// File: doc/BRIEF.md
# Four-Modulus Residue-to-Binary Converter

This block turns a residue vector over the moduli 2^n, 2^(2n+1)-1, 2^n+1 and 2^n-1 back into an ordinary binary integer of 5n+1 bits. The width parameter n is set at build time. n = 10 and n = 12 are the target builds, and any n of at least 3 elaborates. The converter is meant to sit directly behind the arithmetic channels of a residue datapath.

The channels for 2^(2n+1)-1 and 2^n-1 do not finish their own modular carry-propagate additions. They hand over their unresolved carry-save pair (two vectors whose modular sum is the residue). The converter folds each pair, together with the negated subtrahend, through one end-around carry-save row. A single modular carry-propagate adder follows that row. Two cascaded modular adders are therefore replaced by one.

The work is done in two levels. In the first level, two partial combinations run side by side: one merges the 2^n and 2^(2n+1)-1 residues into Z, and the other merges the 2^n+1 and 2^n-1 residues into Y. The second level merges Z and Y into the result. Every modular multiplication by an inverse is a plain bit rotation, because each inverse is a power of two. A parameter chooses ripple or parallel-prefix carry logic for every adder. A second parameter adds or removes one output register.

Top module: `rns_rev4`

## Requirements
- R1: The low n bits of the result equal x1_i, the residue modulo 2^n.
- R2: The result modulo 2^(2n+1)-1 equals (s2_i + c2_i) modulo 2^(2n+1)-1, for any two (2n+1)-bit vectors.
- R3: The result modulo 2^n+1 equals x3_i, which is an (n+1)-bit value in the range 0 to 2^n inclusive.
- R4: The result modulo 2^n-1 equals (s4_i + c4_i) modulo 2^n-1, for any two n-bit vectors.
- R5: The result is the one integer below the dynamic range 2^n·(2^(2n+1)-1)·(2^(2n)-1) that satisfies R1 to R4. It is presented zero-extended on 5n+1 bits.
- R6: An all-ones vector in a carry-save operand counts as zero. For example, s2_i all ones with c2_i all ones, or s2_i all ones with c2_i equal to r, gives the same result as a plain residue of 0 or r.
- R7: With OUT_REG = 1, the result for inputs sampled at a rising clock edge appears after that edge and holds until the next edge. With OUT_REG = 0, the result follows the inputs within the same cycle.
- R8: With OUT_REG = 1, driving the active-low rst_n low clears the output to zero at once, without waiting for a clock, and holds it at zero while rst_n stays low.
- R9: The adder-style parameter (ARCH_RIPPLE or ARCH_PREFIX) changes only the structure of the adders. Both styles give the same result for every input, at n = 3, 10 and 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset for the output register |
| x1_i | input | N | Residue modulo 2^n |
| s2_i | input | 2N+1 | Sum vector of the carry-save pair for modulus 2^(2n+1)-1 |
| c2_i | input | 2N+1 | Carry vector of the carry-save pair for modulus 2^(2n+1)-1 |
| x3_i | input | N+1 | Residue modulo 2^n+1, in the range 0 to 2^n |
| s4_i | input | N | Sum vector of the carry-save pair for modulus 2^n-1 |
| c4_i | input | N | Carry vector of the carry-save pair for modulus 2^n-1 |
| x_o | output | 5N+1 | Binary result, registered or combinational |

## Verification
The checker recomputes all four residues of the output on every cycle and compares them with the inputs that produced it. It also confirms that the output stays below the dynamic range. Together these cover R1 to R5 for whatever inputs arrive, at every n that is built.

Some behaviour only the bench's scenarios can show: the exact cycle at which the registered output changes, the asynchronous clear during reset, the all-ones zero forms, and the agreement between the ripple and prefix builds. The bench shows these with an exhaustive sweep of every integer in the range at n = 3, plus random and edge values at n = 10 and n = 12.

// File: rtl/rns_rev4_pkg.sv
package rns_rev4_pkg;

    // Carry structure used by every internal carry-propagate adder
    typedef enum logic [0:0] {
        ARCH_RIPPLE = 1'b0,
        ARCH_PREFIX = 1'b1
    } adder_arch_e;

endpackage

// File: rtl/rns_cpa.sv
// W-bit carry-propagate adder; the carry structure is picked by ARCH.
module rns_cpa #(
    parameter int W = 8,
    parameter rns_rev4_pkg::adder_arch_e ARCH = rns_rev4_pkg::ARCH_PREFIX
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    localparam int LV = (W > 1) ? $clog2(W) : 1;

    wire [W-1:0] half = a_i ^ b_i;

    if (ARCH == rns_rev4_pkg::ARCH_RIPPLE) begin : g_ripple
        wire [W:0] cy;
        assign cy[0] = cin_i;
        for (genvar i = 0; i < W; i++) begin : g_bit
            assign cy[i+1] = (a_i[i] & b_i[i]) | (half[i] & cy[i]);
        end
        assign sum_o  = half ^ cy[W-1:0];
        assign cout_o = cy[W];
    end else begin : g_prefix
        // Log-depth prefix tree; carry-in folded into bit 0 generate
        for (genvar l = 0; l <= LV; l++) begin : lv
            wire [W-1:0] g;
            wire [W-1:0] p;
            if (l == 0) begin : g_base
                for (genvar i = 0; i < W; i++) begin : g_bit
                    if (i == 0) begin : g_lsb
                        assign g[i] = (a_i[i] & b_i[i]) | (half[i] & cin_i);
                    end else begin : g_rest
                        assign g[i] = a_i[i] & b_i[i];
                    end
                    assign p[i] = half[i];
                end
            end else begin : g_merge
                for (genvar i = 0; i < W; i++) begin : g_bit
                    if (i >= (1 << (l - 1))) begin : g_join
                        assign g[i] = lv[l-1].g[i] | (lv[l-1].p[i] & lv[l-1].g[i-(1<<(l-1))]);
                        assign p[i] = lv[l-1].p[i] & lv[l-1].p[i-(1<<(l-1))];
                    end else begin : g_pass
                        assign g[i] = lv[l-1].g[i];
                        assign p[i] = lv[l-1].p[i];
                    end
                end
            end
        end
        assign sum_o  = half ^ {lv[LV].g[W-2:0], cin_i};
        assign cout_o = lv[LV].g[W-1];
    end

endmodule

// File: rtl/rns_csa_eac.sv
// Three-operand carry-save row modulo 2^K-1: the top carry wraps to bit 0.
module rns_csa_eac #(
    parameter int K = 8
) (
    input  logic [K-1:0] a_i,
    input  logic [K-1:0] b_i,
    input  logic [K-1:0] c_i,
    output logic [K-1:0] sum_o,
    output logic [K-1:0] cy_o
);
    logic [K-1:0] maj;

    always_comb begin
        sum_o = a_i ^ b_i ^ c_i;
        maj   = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
        cy_o  = {maj[K-2:0], maj[K-1]};
    end

endmodule

// File: rtl/rns_modadd.sv
// Adder modulo 2^K-1 with end-around carry; an all-ones sum is returned as zero.
module rns_modadd #(
    parameter int K = 8,
    parameter rns_rev4_pkg::adder_arch_e ARCH = rns_rev4_pkg::ARCH_PREFIX
) (
    input  logic [K-1:0] a_i,
    input  logic [K-1:0] b_i,
    output logic [K-1:0] y_o
);
    logic [K-1:0] raw_sum;
    logic [K-1:0] wrap_sum;
    logic         raw_co;
    logic         wrap_co;

    rns_cpa #(.W(K), .ARCH(ARCH)) u_raw (
        .a_i   (a_i),
        .b_i   (b_i),
        .cin_i (1'b0),
        .sum_o (raw_sum),
        .cout_o(raw_co)
    );

    // Re-inject the carry-out; this second pass cannot overflow again
    rns_cpa #(.W(K), .ARCH(ARCH)) u_wrap (
        .a_i   (raw_sum),
        .b_i   ({K{1'b0}}),
        .cin_i (raw_co),
        .sum_o (wrap_sum),
        .cout_o(wrap_co)
    );

    assign y_o = ((&wrap_sum) | wrap_co) ? {K{1'b0}} : wrap_sum;

endmodule

// File: rtl/rns_mod3.sv
// |a + b + c| mod 2^K-1, then multiplied by 2^ROT (a left rotation).
module rns_mod3 #(
    parameter int K   = 8,
    parameter int ROT = 1,
    parameter rns_rev4_pkg::adder_arch_e ARCH = rns_rev4_pkg::ARCH_PREFIX
) (
    input  logic [K-1:0] a_i,
    input  logic [K-1:0] b_i,
    input  logic [K-1:0] c_i,
    output logic [K-1:0] y_o
);
    logic [K-1:0] row_sum;
    logic [K-1:0] row_cy;
    logic [K-1:0] resid;

    rns_csa_eac #(.K(K)) u_row (
        .a_i  (a_i),
        .b_i  (b_i),
        .c_i  (c_i),
        .sum_o(row_sum),
        .cy_o (row_cy)
    );

    rns_modadd #(.K(K), .ARCH(ARCH)) u_add (
        .a_i(row_sum),
        .b_i(row_cy),
        .y_o(resid)
    );

    if (ROT == 0) begin : g_plain
        assign y_o = resid;
    end else begin : g_rot
        assign y_o = {resid[K-1-ROT:0], resid[K-1:K-ROT]};
    end

endmodule

// File: rtl/rns_rev4.sv
// Residue-to-binary converter for {2^N, 2^(2N+1)-1, 2^N+1, 2^N-1}
module rns_rev4 #(
    parameter int N = 10,
    parameter rns_rev4_pkg::adder_arch_e ARCH = rns_rev4_pkg::ARCH_PREFIX,
    parameter bit OUT_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     x1_i,
    input  logic [2*N:0]     s2_i,
    input  logic [2*N:0]     c2_i,
    input  logic [N:0]       x3_i,
    input  logic [N-1:0]     s4_i,
    input  logic [N-1:0]     c4_i,
    output logic [5*N:0]     x_o
);
    localparam int W2 = 2 * N + 1;   // width of the 2^(2N+1)-1 channel
    localparam int WY = 2 * N;       // width of Y and of the final modulus
    localparam int WZ = 3 * N + 1;   // width of Z
    localparam int XW = 5 * N + 1;   // width of the result

    typedef struct packed {
        logic [XW-1:0] x;
    } out_s;

    out_s st_d, st_q;

    // ---- first level, Z branch: x1 with the (s2, c2) pair ----
    logic [W2-1:0] t1;
    logic [WZ-1:0] z_val;

    rns_mod3 #(.K(W2), .ROT(N + 1), .ARCH(ARCH)) u_zdiff (
        .a_i(s2_i),
        .b_i(c2_i),
        .c_i(~{{(N + 1){1'b0}}, x1_i}),
        .y_o(t1)
    );

    assign z_val = {t1, x1_i};

    // ---- first level, Y branch: x3 with the (s4, c4) pair ----
    logic [N-1:0] x3_fold;
    logic [N-1:0] t2;

    // 2^N is congruent to 1 modulo 2^N-1 and only occurs with low bits clear
    assign x3_fold = {x3_i[N-1:1], x3_i[0] | x3_i[N]};

    rns_mod3 #(.K(N), .ROT(N - 1), .ARCH(ARCH)) u_ydiff (
        .a_i(s4_i),
        .b_i(c4_i),
        .c_i(~x3_fold),
        .y_o(t2)
    );

    // Y = x3 + t2*2^N + t2 via one carry-save row and one adder
    logic [WY-1:0] y_rs;
    logic [WY-1:0] y_rc;
    logic [WY-1:0] y_val;
    logic          y_carry_unused;

    always_comb begin
        logic [WY-1:0] op_a, op_b, op_c;
        op_a = {t2, {N{1'b0}}};
        op_b = {{N{1'b0}}, t2};
        op_c = {{(N - 1){1'b0}}, x3_i};
        y_rs = op_a ^ op_b ^ op_c;
        y_rc = {((op_a[WY-2:0] & op_b[WY-2:0]) | (op_a[WY-2:0] & op_c[WY-2:0])
                 | (op_b[WY-2:0] & op_c[WY-2:0])), 1'b0};
    end

    rns_cpa #(.W(WY), .ARCH(ARCH)) u_yadd (
        .a_i   (y_rs),
        .b_i   (y_rc),
        .cin_i (1'b0),
        .sum_o (y_val),
        .cout_o(y_carry_unused)
    );

    // ---- second level: |2^N (Y - Z)| mod 2^(2N)-1, Z folded in two chunks ----
    logic [WY-1:0] t3;

    rns_mod3 #(.K(WY), .ROT(N), .ARCH(ARCH)) u_xdiff (
        .a_i(y_val),
        .b_i(~z_val[WY-1:0]),
        .c_i(~{{(N - 1){1'b0}}, z_val[WZ-1:WY]}),
        .y_o(t3)
    );

    // X = Z + t3*2^(3N+1) - t3*2^N
    logic [XW-1:0] x_rs;
    logic [XW-1:0] x_rc;
    logic [XW-1:0] x_full;
    logic          x_carry_unused;

    always_comb begin
        logic [XW-1:0] op_a, op_b, op_c;
        op_a = {{(XW - WZ){1'b0}}, z_val};
        op_b = {t3, {WZ{1'b0}}};
        op_c = ~{{(W2){1'b0}}, t3, {N{1'b0}}};
        x_rs = op_a ^ op_b ^ op_c;
        x_rc = {((op_a[XW-2:0] & op_b[XW-2:0]) | (op_a[XW-2:0] & op_c[XW-2:0])
                 | (op_b[XW-2:0] & op_c[XW-2:0])), 1'b0};
    end

    rns_cpa #(.W(XW), .ARCH(ARCH)) u_xadd (
        .a_i   (x_rs),
        .b_i   (x_rc),
        .cin_i (1'b1),
        .sum_o (x_full),
        .cout_o(x_carry_unused)
    );

    // ---- next-state and output register ----
    always_comb begin
        st_d   = st_q;
        st_d.x = x_full;
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q <= '0;
            end else begin
                st_q <= st_d;
            end
        end
    end else begin : g_comb
        assign st_q = st_d;
    end

    assign x_o = st_q.x;

endmodule

// File: rtl/rns_rev4_chk.sv
// Checker: residues of the output against the inputs that produced it.
module rns_rev4_chk #(
    parameter int N = 10,
    parameter bit OUT_REG = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] x1_i,
    input logic [2*N:0] s2_i,
    input logic [2*N:0] c2_i,
    input logic [N:0]   x3_i,
    input logic [N-1:0] s4_i,
    input logic [N-1:0] c4_i,
    input logic [5*N:0] x_o
);
    localparam logic [63:0] P1 = 64'd1 << N;
    localparam logic [63:0] M2 = (64'd1 << (2 * N + 1)) - 64'd1;
    localparam logic [63:0] M3 = P1 + 64'd1;
    localparam logic [63:0] M4 = P1 - 64'd1;
    localparam logic [63:0] RNG = P1 * M2 * ((64'd1 << (2 * N)) - 64'd1);

    logic [N-1:0] x1_r;
    logic [2*N:0] s2_r, c2_r;
    logic [N:0]   x3_r;
    logic [N-1:0] s4_r, c4_r;
    logic         armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    if (OUT_REG) begin : g_ref_reg
        always_ff @(posedge clk) begin
            x1_r <= x1_i;
            s2_r <= s2_i;
            c2_r <= c2_i;
            x3_r <= x3_i;
            s4_r <= s4_i;
            c4_r <= c4_i;
        end
    end else begin : g_ref_comb
        always_comb begin
            x1_r = x1_i;
            s2_r = s2_i;
            c2_r = c2_i;
            x3_r = x3_i;
            s4_r = s4_i;
            c4_r = c4_i;
        end
    end

    wire [63:0] y64 = 64'(x_o);

    // R1
    r1_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (x_o[N-1:0] == x1_r));

    // R2
    r2_wide_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> ((y64 % M2) == ((64'(s2_r) + 64'(c2_r)) % M2)));

    // R3
    r3_plus_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && (64'(x3_r) <= P1)) |-> ((y64 % M3) == 64'(x3_r)));

    // R4
    r4_minus_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> ((y64 % M4) == ((64'(s4_r) + 64'(c4_r)) % M4)));

    // R5
    r5_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && (64'(x3_r) <= P1)) |-> (y64 < RNG));

endmodule

bind rns_rev4 rns_rev4_chk #(.N(N), .OUT_REG(OUT_REG)) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .x1_i (x1_i),
    .s2_i (s2_i),
    .c2_i (c2_i),
    .x3_i (x3_i),
    .s4_i (s4_i),
    .c4_i (c4_i),
    .x_o  (x_o)
);

// File: tb/sim_rns_rev4.sv
module sim_rns_rev4;
    import rns_rev4_pkg::*;

    localparam int NA = 3;
    localparam int NB = 10;
    localparam int NC = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    int checks = 0;
    int errors = 0;

    // group A: n = 3, registered prefix (u0) and combinational ripple (u1)
    logic [NA-1:0]   a_x1, a_s4, a_c4;
    logic [2*NA:0]   a_s2, a_c2;
    logic [NA:0]     a_x3;
    logic [5*NA:0]   ya0, ya1;
    // group B: n = 10, ripple, combinational
    logic [NB-1:0]   b_x1, b_s4, b_c4;
    logic [2*NB:0]   b_s2, b_c2;
    logic [NB:0]     b_x3;
    logic [5*NB:0]   yb;
    // group C: n = 12, prefix, combinational
    logic [NC-1:0]   c_x1, c_s4, c_c4;
    logic [2*NC:0]   c_s2, c_c2;
    logic [NC:0]     c_x3;
    logic [5*NC:0]   yc;

    rns_rev4 #(.N(NA), .ARCH(ARCH_PREFIX), .OUT_REG(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .x1_i(a_x1), .s2_i(a_s2), .c2_i(a_c2),
        .x3_i(a_x3), .s4_i(a_s4), .c4_i(a_c4), .x_o(ya0));
    rns_rev4 #(.N(NA), .ARCH(ARCH_RIPPLE), .OUT_REG(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .x1_i(a_x1), .s2_i(a_s2), .c2_i(a_c2),
        .x3_i(a_x3), .s4_i(a_s4), .c4_i(a_c4), .x_o(ya1));
    rns_rev4 #(.N(NB), .ARCH(ARCH_RIPPLE), .OUT_REG(1'b0)) u2 (
        .clk(clk), .rst_n(rst_n), .x1_i(b_x1), .s2_i(b_s2), .c2_i(b_c2),
        .x3_i(b_x3), .s4_i(b_s4), .c4_i(b_c4), .x_o(yb));
    rns_rev4 #(.N(NC), .ARCH(ARCH_PREFIX), .OUT_REG(1'b0)) u3 (
        .clk(clk), .rst_n(rst_n), .x1_i(c_x1), .s2_i(c_s2), .c2_i(c_c2),
        .x3_i(c_x3), .s4_i(c_s4), .c4_i(c_c4), .x_o(yc));

    function automatic logic [63:0] pw(input int k);
        return 64'd1 << k;
    endfunction

    function automatic logic [63:0] span(input int n);
        return pw(n) * (pw(2 * n + 1) - 64'd1) * (pw(2 * n) - 64'd1);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // carry-save pair whose sum is r modulo m (m is all ones, so it is also the mask)
    task automatic pair(input logic [63:0] r, input logic [63:0] m, input bit alt,
                        output logic [63:0] s, output logic [63:0] c);
        if (alt) begin
            s = m;                      // all-ones form of zero
            c = (r == 0) ? m : r;
        end else begin
            s = {$urandom(), $urandom()} & m;
            c = (r + m - (s % m)) % m;
        end
    endtask

    task automatic gen(input logic [63:0] x, input int n, input bit alt,
                       output logic [63:0] x1, output logic [63:0] s2, output logic [63:0] c2,
                       output logic [63:0] x3, output logic [63:0] s4, output logic [63:0] c4);
        x1 = x % pw(n);
        x3 = x % (pw(n) + 64'd1);
        pair(x % (pw(2 * n + 1) - 64'd1), pw(2 * n + 1) - 64'd1, alt, s2, c2);
        pair(x % (pw(n) - 64'd1), pw(n) - 64'd1, alt, s4, c4);
    endtask

    task automatic check_res(input logic [63:0] y, input logic [63:0] x, input int n);
        logic [63:0] m2, m3, m4;
        m2 = pw(2 * n + 1) - 64'd1;
        m3 = pw(n) + 64'd1;
        m4 = pw(n) - 64'd1;
        chk("R1", y % pw(n), x % pw(n));
        chk("R2", y % m2, x % m2);
        chk("R3", y % m3, x % m3);
        chk("R4", y % m4, x % m4);
        chk("R5", y, x);
    endtask

    task automatic drive_a(input logic [63:0] x, input bit alt);
        logic [63:0] v1, v2, v3, v4, v5, v6;
        gen(x, NA, alt, v1, v2, v3, v4, v5, v6);
        a_x1 = v1[NA-1:0];  a_s2 = v2[2*NA:0]; a_c2 = v3[2*NA:0];
        a_x3 = v4[NA:0];    a_s4 = v5[NA-1:0]; a_c4 = v6[NA-1:0];
    endtask

    task automatic run_b(input logic [63:0] x, input bit alt);
        logic [63:0] v1, v2, v3, v4, v5, v6;
        @(negedge clk);
        gen(x, NB, alt, v1, v2, v3, v4, v5, v6);
        b_x1 = v1[NB-1:0];  b_s2 = v2[2*NB:0]; b_c2 = v3[2*NB:0];
        b_x3 = v4[NB:0];    b_s4 = v5[NB-1:0]; b_c4 = v6[NB-1:0];
        #1;
        check_res(64'(yb), x, NB);
        if (alt) chk("R6", 64'(yb), x);
        chk("R9", 64'(yb) % pw(NB), x % pw(NB));
    endtask

    task automatic run_c(input logic [63:0] x, input bit alt);
        logic [63:0] v1, v2, v3, v4, v5, v6;
        @(negedge clk);
        gen(x, NC, alt, v1, v2, v3, v4, v5, v6);
        c_x1 = v1[NC-1:0];  c_s2 = v2[2*NC:0]; c_c2 = v3[2*NC:0];
        c_x3 = v4[NC:0];    c_s4 = v5[NC-1:0]; c_c4 = v6[NC-1:0];
        #1;
        check_res(64'(yc), x, NC);
        if (alt) chk("R6", 64'(yc), x);
        chk("R9", 64'(yc), x);
    endtask

    initial begin
        logic [63:0] prev_x, prev_y1, dra;
        bit prev_ok;
        dra = span(NA);
        b_x1 = '0; b_s2 = '0; b_c2 = '0; b_x3 = '0; b_s4 = '0; b_c4 = '0;
        c_x1 = '0; c_s2 = '0; c_c2 = '0; c_x3 = '0; c_s4 = '0; c_c4 = '0;

        // R8: reset state with a nonzero vector applied
        drive_a(64'd12345, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8", 64'(ya0), 64'd0);
        rst_n = 1'b1;

        // exhaustive sweep of the n = 3 range
        prev_ok = 1'b0;
        prev_x  = '0;
        prev_y1 = '0;
        for (logic [63:0] x = 0; x < dra; x++) begin
            bit alt;
            @(negedge clk);
            if (prev_ok) begin
                chk("R7", 64'(ya0), prev_x);      // captured at the last edge
                chk("R9", 64'(ya0), prev_y1);     // prefix build equals ripple build
            end
            alt = (x % 3 == 2);
            drive_a(x, alt);
            #1;
            check_res(64'(ya1), x, NA);
            if (alt) chk("R6", 64'(ya1), x);
            if (prev_ok) chk("R7", 64'(ya0), prev_x);   // not yet updated
            prev_x  = x;
            prev_y1 = 64'(ya1);
            prev_ok = 1'b1;
        end
        @(negedge clk);
        chk("R7", 64'(ya0), prev_x);

        // R8: asynchronous clear between edges, then recovery
        #1;
        rst_n = 1'b0;
        #1;
        chk("R8", 64'(ya0), 64'd0);
        @(posedge clk);
        @(negedge clk);
        chk("R8", 64'(ya0), 64'd0);
        rst_n = 1'b1;
        drive_a(64'd777, 1'b0);
        @(negedge clk);
        chk("R7", 64'(ya0), 64'd777);

        // n = 10 and n = 12: edge values, then random values
        run_b(64'd0, 1'b0);
        run_b(64'd0, 1'b1);
        run_b(64'd1, 1'b0);
        run_b(span(NB) - 64'd1, 1'b0);
        run_b(span(NB) / 2, 1'b1);
        run_c(64'd0, 1'b1);
        run_c(pw(NC) - 64'd1, 1'b0);
        run_c(span(NC) - 64'd1, 1'b1);
        run_c(span(NC) - 64'd2, 1'b0);
        for (int i = 0; i < 400; i++) begin
            run_b({$urandom(), $urandom()} % span(NB), (i % 4 == 0));
            run_c({$urandom(), $urandom()} % span(NC), (i % 4 == 1));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R7 actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule